// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog for a chip's system controller. A 16-bit counter climbs from a value that software loads. A prescaler divides a count-clock enable by one of eight ratios and paces the counter. When the counter wraps past its all-ones value, the block raises a one-cycle reset request toward the reset controller. It also sets a sticky status flag, and that flag outlives the soft reset the request causes. To set a timeout of N counted ticks, software loads 65536 − N. To service the watchdog, software reloads that value.

The block is programmed through a single-cycle 32-bit register port. A write only counts if its upper bits carry a guard pattern. Each kind of register has its own pattern, so a stray store cannot disarm or feed the watchdog. A write that passes the guard does not land at once. It waits in a small transfer machine that steps only on count-clock enables, which models the latency of moving the write into the slower counting domain. The transfer machine has three states:
- XF_IDLE moves to XF_HOLD1 when a guarded write is accepted.
- XF_HOLD1 moves to XF_HOLD2 on the next count-clock enable.
- XF_HOLD2 moves back to XF_IDLE on the following enable. The held write takes effect on that same edge.

While the machine is out of XF_IDLE, a busy bit reads as 1, and any further write is dropped.

Top module: `key_wdog`

## Requirements
- R1: After the power-on reset `por_n`, all three registers read 0 and `rst_req` is 0.
- R2: A write to offset 0x0 is accepted only when bits 31:16 are 0x5A5A. Bits 15:0 then become the counter value. A write with any other upper half changes nothing and does not set the busy bit.
- R3: A write to offset 0x4 or 0x8 is accepted only when bits 31:8 are 0xA5A5A5, and bits 7:0 are its payload. A write with any other key changes nothing, and that includes leaving the status flag set.
- R4: After an accepted write, bit 5 of the control register at 0x4 (busy) reads 1 for exactly two count-clock enables. The written value becomes visible on the edge where busy drops.
- R5: Any write that arrives while busy is 1 is dropped, and it takes no effect later either.
- R6: While bit 7 of 0x4 (enable) is 1, the counter advances by one every D count-clock enables. Select code 0–7 in bits 2:0 of 0x4 gives D = 1, 4, 16, 32, 64, 128, 1024 or 4096. Loading the counter restarts the division.
- R7: While enable is 0, the counter holds its value, and reads at 0x0 return it.
- R8: An increment from 0xFFFF wraps the counter to 0x0000. It sets the status flag (bit 4 of 0x4) and drives `rst_req` high for exactly one cycle, in the cycle after the wrapping edge.
- R9: Loading 0xFFFF while enable is 1 overflows on the next counted tick, which comes D enables after the load takes effect.
- R10: `soft_rst_n` low clears the counter, enable, select, register 0x8 and any pending write, and it keeps the status flag. `por_n` clears the flag as well.
- R11: An accepted write to 0x4 with bit 4 = 0 clears the status flag, and one with bit 4 = 1 leaves it unchanged. Writes never set the flag.
- R12: While `cnt_en` is 0, neither the counter nor the prescaler advances, and a held write stays pending with busy at 1.
- R13: Register 0x4 reads as {enable, 0, busy, flag, 0, select[2:0]}, and writes to bits 6, 5 and 3 have no effect. Register 0x8 stores and returns its 8-bit payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low, clears everything |
| soft_rst_n | input | 1 | Synchronous system reset, active low, keeps the status flag |
| cnt_en | input | 1 | Count-clock enable, paces the prescaler and the write transfer |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write word, guard key in the upper bits |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
An accepted write is sampled at edge E0. Busy reads 1 after E0 and after E1, and the value is visible after E2 when `cnt_en` is held high. After an enable takes effect at E2, the counter's k-th step lands on edge E2 + k·D. An overflow shows on `rst_req` and on the flag after the wrapping edge, and `rst_req` drops one edge later. The bench drives on falling edges and counts falling edges from each write. It reads every register just after the falling edge that follows the edge where the result is due, so each check lands in its own cycle. For every select code it samples both one tick before and exactly at the third step.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    // Write-transfer machine states
    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_HOLD1 = 2'd1,
        XF_HOLD2 = 2'd2
    } xfer_state_e;

    // Target of a held register write
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL_A = 2'd2,
        SEL_CTRL_B = 2'd3
    } reg_sel_e;

    // Bit positions inside control register A
    localparam int unsigned CSA_EN_BIT  = 7;
    localparam int unsigned CSA_WIP_BIT = 5;
    localparam int unsigned CSA_OVF_BIT = 4;
    localparam int unsigned SELECT_W    = 3;

    // Largest prescaler shift; sizes the prescaler counter
    localparam int unsigned MAX_SHIFT = 12;

    // Division ratio as a power of two for each select code
    function automatic logic [3:0] div_shift(input logic [SELECT_W-1:0] code);
        logic [3:0] sh;
        unique case (code)
            3'd0:    sh = 4'd0;
            3'd1:    sh = 4'd2;
            3'd2:    sh = 4'd4;
            3'd3:    sh = 4'd5;
            3'd4:    sh = 4'd6;
            3'd5:    sh = 4'd7;
            3'd6:    sh = 4'd10;
            default: sh = 4'd12;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/wdk_bus_dec.sv
module wdk_bus_dec
    import wdk_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned CTL_W  = 8,
    parameter logic [DATA_W-CNT_W-1:0] KEY_CNT = 'h5A5A,
    parameter logic [DATA_W-CTL_W-1:0] KEY_CTL = 'hA5A5A5
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  count_val,
    input  logic [CTL_W-1:0]  csa_val,
    input  logic [CTL_W-1:0]  csb_val,
    output logic              wr_valid,
    output reg_sel_e          wr_sel,
    output logic [CNT_W-1:0]  wr_data,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] ADR_COUNT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_CTLA  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] ADR_CTLB  = ADDR_W'(8);

    logic cnt_key_ok;
    logic ctl_key_ok;

    assign cnt_key_ok = (bus_wdata[DATA_W-1:CNT_W] == KEY_CNT);
    assign ctl_key_ok = (bus_wdata[DATA_W-1:CTL_W] == KEY_CTL);

    // Write decode and guard check
    always_comb begin
        wr_valid = 1'b0;
        wr_sel   = SEL_NONE;
        wr_data  = '0;
        unique case (bus_addr)
            ADR_COUNT: begin
                wr_sel   = SEL_COUNT;
                wr_data  = bus_wdata[CNT_W-1:0];
                wr_valid = bus_we && cnt_key_ok;
            end
            ADR_CTLA: begin
                wr_sel   = SEL_CTRL_A;
                wr_data  = CNT_W'(bus_wdata[CTL_W-1:0]);
                wr_valid = bus_we && ctl_key_ok;
            end
            ADR_CTLB: begin
                wr_sel   = SEL_CTRL_B;
                wr_data  = CNT_W'(bus_wdata[CTL_W-1:0]);
                wr_valid = bus_we && ctl_key_ok;
            end
            default: begin
                wr_valid = 1'b0;
            end
        endcase
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_COUNT: bus_rdata = DATA_W'(count_val);
            ADR_CTLA:  bus_rdata = DATA_W'(csa_val);
            ADR_CTLB:  bus_rdata = DATA_W'(csb_val);
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdk_xfer_fsm.sv
module wdk_xfer_fsm
    import wdk_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             soft_rst_n,
    input  logic             cnt_en,
    input  logic             req_valid,
    input  reg_sel_e         req_sel,
    input  logic [CNT_W-1:0] req_data,
    output logic             busy,
    output logic             ld_count,
    output logic             ld_ctla,
    output logic             ld_ctlb,
    output logic [CNT_W-1:0] ld_data
);

    xfer_state_e      state_q;
    xfer_state_e      state_d;
    reg_sel_e         pend_sel_q;
    logic [CNT_W-1:0] pend_data_q;
    logic             commit;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= XF_IDLE;
        end else if (!soft_rst_n) begin
            state_q <= XF_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE:  if (req_valid) state_d = XF_HOLD1;
            XF_HOLD1: if (cnt_en)    state_d = XF_HOLD2;
            XF_HOLD2: if (cnt_en)    state_d = XF_IDLE;
            default:                 state_d = XF_IDLE;
        endcase
    end

    // Held write, captured only when the machine is free
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pend_sel_q  <= SEL_NONE;
            pend_data_q <= '0;
        end else if (state_q == XF_IDLE && req_valid) begin
            pend_sel_q  <= req_sel;
            pend_data_q <= req_data;
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != XF_IDLE);
        commit   = (state_q == XF_HOLD2) && cnt_en;
        ld_count = commit && (pend_sel_q == SEL_COUNT);
        ld_ctla  = commit && (pend_sel_q == SEL_CTRL_A);
        ld_ctlb  = commit && (pend_sel_q == SEL_CTRL_B);
        ld_data  = pend_data_q;
    end

endmodule

// File: rtl/wdk_ctrl_regs.sv
module wdk_ctrl_regs
    import wdk_pkg::*;
#(
    parameter int unsigned CTL_W = 8
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                soft_rst_n,
    input  logic                ld_ctla,
    input  logic                ld_ctlb,
    input  logic [CTL_W-1:0]    ld_data,
    input  logic                ovf_evt,
    input  logic                busy,
    output logic                tme,
    output logic [SELECT_W-1:0] cks,
    output logic                flag,
    output logic [CTL_W-1:0]    ctlb,
    output logic [CTL_W-1:0]    csa_val
);

    // Enable, select and register B: cleared by either reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            tme  <= 1'b0;
            cks  <= '0;
            ctlb <= '0;
        end else if (!soft_rst_n) begin
            tme  <= 1'b0;
            cks  <= '0;
            ctlb <= '0;
        end else begin
            if (ld_ctla) begin
                tme <= ld_data[CSA_EN_BIT];
                cks <= ld_data[SELECT_W-1:0];
            end
            if (ld_ctlb) begin
                ctlb <= ld_data;
            end
        end
    end

    // Overflow status: only power-on reset clears it; set beats clear
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag <= 1'b0;
        end else if (ovf_evt) begin
            flag <= 1'b1;
        end else if (soft_rst_n && ld_ctla && !ld_data[CSA_OVF_BIT]) begin
            flag <= 1'b0;
        end
    end

    always_comb begin
        csa_val                 = '0;
        csa_val[CSA_EN_BIT]     = tme;
        csa_val[CSA_WIP_BIT]    = busy;
        csa_val[CSA_OVF_BIT]    = flag;
        csa_val[SELECT_W-1:0]   = cks;
    end

endmodule

// File: rtl/wdk_count_core.sv
module wdk_count_core
    import wdk_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PS_W  = 12
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                soft_rst_n,
    input  logic                cnt_en,
    input  logic                tme,
    input  logic [SELECT_W-1:0] cks,
    input  logic                ld_count,
    input  logic [CNT_W-1:0]    ld_data,
    output logic [CNT_W-1:0]    count,
    output logic                ovf_evt,
    output logic                rst_req
);

    logic [PS_W-1:0] presc_q;
    logic [PS_W:0]   span;
    logic [PS_W-1:0] limit;
    logic            tick;

    // Terminal prescaler value for the selected ratio
    assign span  = (PS_W+1)'(1) << div_shift(cks);
    assign limit = PS_W'(span - (PS_W+1)'(1));
    assign tick  = tme && cnt_en && (presc_q >= limit);

    assign ovf_evt = tick && (count == '1) && !ld_count && soft_rst_n;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            presc_q <= '0;
            count   <= '0;
            rst_req <= 1'b0;
        end else if (!soft_rst_n) begin
            presc_q <= '0;
            count   <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= ovf_evt;
            if (ld_count) begin
                count   <= ld_data;
                presc_q <= '0;
            end else begin
                if (!tme) begin
                    presc_q <= '0;
                end else if (cnt_en) begin
                    presc_q <= tick ? '0 : presc_q + PS_W'(1);
                end
                if (tick) begin
                    count <= count + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/key_wdog.sv
module key_wdog
    import wdk_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned CTL_W  = 8,
    parameter logic [DATA_W-CNT_W-1:0] KEY_CNT = 'h5A5A,
    parameter logic [DATA_W-CTL_W-1:0] KEY_CTL = 'hA5A5A5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst_n,
    input  logic              cnt_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);

    localparam int unsigned PS_W = MAX_SHIFT;

    logic                wr_valid;
    reg_sel_e            wr_sel;
    logic [CNT_W-1:0]    wr_data;
    logic                xfer_busy;
    logic                ld_count;
    logic                ld_ctla;
    logic                ld_ctlb;
    logic [CNT_W-1:0]    ld_data;
    logic                tme_q;
    logic [SELECT_W-1:0] cks_q;
    logic                flag_q;
    logic [CTL_W-1:0]    ctlb_q;
    logic [CTL_W-1:0]    csa_val;
    logic [CNT_W-1:0]    cnt_q;
    logic                ovf_evt;

    wdk_bus_dec #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .CTL_W  (CTL_W),
        .KEY_CNT(KEY_CNT),
        .KEY_CTL(KEY_CTL)
    ) u_bus_dec (
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .count_val(cnt_q),
        .csa_val  (csa_val),
        .csb_val  (ctlb_q),
        .wr_valid (wr_valid),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .bus_rdata(bus_rdata)
    );

    wdk_xfer_fsm #(
        .CNT_W(CNT_W)
    ) u_xfer (
        .clk       (clk),
        .por_n     (por_n),
        .soft_rst_n(soft_rst_n),
        .cnt_en    (cnt_en),
        .req_valid (wr_valid),
        .req_sel   (wr_sel),
        .req_data  (wr_data),
        .busy      (xfer_busy),
        .ld_count  (ld_count),
        .ld_ctla   (ld_ctla),
        .ld_ctlb   (ld_ctlb),
        .ld_data   (ld_data)
    );

    wdk_ctrl_regs #(
        .CTL_W(CTL_W)
    ) u_ctrl (
        .clk       (clk),
        .por_n     (por_n),
        .soft_rst_n(soft_rst_n),
        .ld_ctla   (ld_ctla),
        .ld_ctlb   (ld_ctlb),
        .ld_data   (ld_data[CTL_W-1:0]),
        .ovf_evt   (ovf_evt),
        .busy      (xfer_busy),
        .tme       (tme_q),
        .cks       (cks_q),
        .flag      (flag_q),
        .ctlb      (ctlb_q),
        .csa_val   (csa_val)
    );

    wdk_count_core #(
        .CNT_W(CNT_W),
        .PS_W (PS_W)
    ) u_core (
        .clk       (clk),
        .por_n     (por_n),
        .soft_rst_n(soft_rst_n),
        .cnt_en    (cnt_en),
        .tme       (tme_q),
        .cks       (cks_q),
        .ld_count  (ld_count),
        .ld_data   (ld_data),
        .count     (cnt_q),
        .ovf_evt   (ovf_evt),
        .rst_req   (rst_req)
    );

endmodule

// File: rtl/wdk_chk.sv
module wdk_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             por_n,
    input logic             soft_rst_n,
    input logic             cnt_en,
    input logic             rst_req,
    input logic             tme,
    input logic             flag,
    input logic             busy,
    input logic             ld_count,
    input logic [CNT_W-1:0] count
);

    // R8: the request lasts a single cycle
    assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);

    // R8: a request always comes with the status flag set
    assert_req_flag_R8: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> flag);

    // R8: the request follows a wrap to zero
    assert_req_wrap_R8: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> (count == '0));

    // R6: without a load the counter moves by at most one step
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!por_n)
        (soft_rst_n && !ld_count) |=>
            ((count == $past(count)) || (count == CNT_W'($past(count) + CNT_W'(1)))));

    // R7: disabled counter is frozen
    assert_count_frozen_R7: assert property (@(posedge clk) disable iff (!por_n)
        (soft_rst_n && !tme && !ld_count) |=> $stable(count));

    // R12: a held write does not advance without a count enable
    assert_hold_stall_R12: assert property (@(posedge clk) disable iff (!por_n)
        (busy && !cnt_en && soft_rst_n) |=> busy);

    // R4: loads come only out of the busy window
    assert_load_in_window_R4: assert property (@(posedge clk) disable iff (!por_n)
        ld_count |-> busy);

    // R10: soft reset never drops the status flag
    assert_flag_kept_R10: assert property (@(posedge clk) disable iff (!por_n)
        (!soft_rst_n && flag) |=> flag);

endmodule

bind key_wdog wdk_chk #(
    .CNT_W(CNT_W)
) u_wdk_chk (
    .clk       (clk),
    .por_n     (por_n),
    .soft_rst_n(soft_rst_n),
    .cnt_en    (cnt_en),
    .rst_req   (rst_req),
    .tme       (tme_q),
    .flag      (flag_q),
    .busy      (xfer_busy),
    .ld_count  (ld_count),
    .count     (cnt_q)
);

// File: tb/tb_key_wdog.sv
module tb_key_wdog;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 200000;

    logic        clk = 1'b0;
    logic        por_n;
    logic        soft_rst_n;
    logic        cnt_en;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int n_total = 0;
    int n_bad   = 0;
    bit done    = 1'b0;

    logic [31:0] s_cnt, s_csa, s_csb;
    logic        s_req;

    key_wdog dut (
        .clk       (clk),
        .por_n     (por_n),
        .soft_rst_n(soft_rst_n),
        .cnt_en    (cnt_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a falling edge; the write is sampled at the next rising edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic snap();
        bus_addr = 4'h0; #1 s_cnt = bus_rdata;
        bus_addr = 4'h4; #1 s_csa = bus_rdata;
        bus_addr = 4'h8; #1 s_csb = bus_rdata;
        s_req = rst_req;
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        por_n = 1'b0; soft_rst_n = 1'b1; cnt_en = 1'b1;
        bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
        tick_n(3);
        por_n = 1'b1;
        tick_n(1);

        // R1 reset state
        snap();
        check("R1 count", s_cnt, 32'h0);
        check("R1 ctrlA", s_csa, 32'h0);
        check("R1 ctrlB", s_csb, 32'h0);
        check("R1 rst_req", {31'b0, s_req}, 32'h0);

        // R2/R4 keyed count write and busy window
        tick_n(1);
        wr(4'h0, 32'h5A5A_1234);
        snap();
        check("R4 busy after accept", s_csa & 32'h20, 32'h20);
        check("R4 value not yet visible", s_cnt, 32'h0);
        tick_n(1); snap();
        check("R4 busy second enable", s_csa & 32'h20, 32'h20);
        tick_n(1); snap();
        check("R4 busy dropped", s_csa & 32'h20, 32'h0);
        check("R2 count loaded", s_cnt, 32'h1234);

        // R2 wrong count key
        tick_n(1);
        wr(4'h0, 32'h5A5B_0001);
        snap();
        check("R2 bad key not busy", s_csa & 32'h20, 32'h0);
        tick_n(3); snap();
        check("R2 bad key ignored", s_cnt, 32'h1234);

        // R3 wrong control key; R7 frozen while disabled
        wr(4'h4, 32'hA5A4_A580);
        tick_n(3); snap();
        check("R3 bad ctrl key ignored", s_csa, 32'h0);
        check("R7 frozen count", s_cnt, 32'h1234);

        // R5 write during busy dropped
        tick_n(1);
        wr(4'h0, 32'h5A5A_0100);
        wr(4'h0, 32'h5A5A_0200);
        tick_n(1); snap();
        check("R5 first write kept", s_cnt, 32'h0100);
        tick_n(3); snap();
        check("R5 second write never lands", s_cnt, 32'h0100);

        // R13 register B and read-only bits of A
        wr(4'h8, 32'hA5A5_A5C3);
        tick_n(2); snap();
        check("R13 ctrlB stores", s_csb, 32'hC3);
        wr(4'h8, 32'h00A5_A5FF);
        tick_n(3); snap();
        check("R3 ctrlB bad key", s_csb, 32'hC3);
        wr(4'h4, 32'hA5A5_A568);
        tick_n(2); snap();
        check("R13 ctrlA unused bits", s_csa, 32'h0);

        // R6 sweep of every prescaler code; R7 freeze after disable
        for (int code = 0; code < 8; code++) begin
            int sh;
            int dv;
            sh = (code < 2) ? 2 * code : ((code < 6) ? code + 2 : ((code == 6) ? 10 : 12));
            dv = 1 << sh;
            tick_n(1);
            wr(4'h0, 32'h5A5A_0000);
            tick_n(2);
            wr(4'h4, 32'hA5A5_A580 | 32'(code));
            tick_n(2);
            tick_n(3 * dv - 1); snap();
            check($sformatf("R6 code %0d before third step", code), s_cnt, 32'd2);
            tick_n(1); snap();
            check($sformatf("R6 code %0d third step", code), s_cnt, 32'd3);
            wr(4'h4, 32'hA5A5_A500 | 32'(code));
            tick_n(2); snap();
            v = s_cnt;
            check($sformatf("R13 select readback %0d", code), s_csa, 32'(code));
            tick_n(40); snap();
            check($sformatf("R7 freeze code %0d", code), s_cnt, v);
        end

        // R12 count enable low stalls counting and transfer
        tick_n(1);
        wr(4'h0, 32'h5A5A_0050);
        tick_n(2);
        wr(4'h4, 32'hA5A5_A580);
        tick_n(2);
        cnt_en = 1'b0;
        tick_n(20); snap();
        check("R12 count stalled", s_cnt, 32'h0050);
        tick_n(1);
        wr(4'h0, 32'h5A5A_0777);
        tick_n(10); snap();
        check("R12 busy held", s_csa & 32'h20, 32'h20);
        check("R12 load pending", s_cnt, 32'h0050);
        tick_n(1);
        cnt_en = 1'b1;
        tick_n(2); snap();
        check("R12 load after enables", s_cnt, 32'h0777);
        check("R12 busy released", s_csa & 32'h20, 32'h0);

        // R8/R9 overflow at divide-by-1
        wr(4'h0, 32'h5A5A_FFFF);
        tick_n(2); snap();
        check("R9 loaded all ones", s_cnt, 32'hFFFF);
        check("R8 no request yet", {31'b0, s_req}, 32'h0);
        check("R8 flag clear before wrap", s_csa, 32'h80);
        tick_n(1); snap();
        check("R9 request next tick", {31'b0, s_req}, 32'h1);
        check("R8 wrapped to zero", s_cnt, 32'h0);
        check("R8 flag set", s_csa, 32'h90);
        tick_n(1); snap();
        check("R8 request one cycle", {31'b0, s_req}, 32'h0);
        check("R8 counting resumes", s_cnt, 32'h1);

        // R9 overflow at divide-by-16
        wr(4'h4, 32'hA5A5_A592);
        tick_n(2); snap();
        check("R11 bit4 one keeps flag", s_csa, 32'h92);
        wr(4'h0, 32'h5A5A_FFFF);
        tick_n(2);
        tick_n(15); snap();
        check("R9 no request before tick", {31'b0, s_req}, 32'h0);
        check("R9 still all ones", s_cnt, 32'hFFFF);
        tick_n(1); snap();
        check("R9 request at tick", {31'b0, s_req}, 32'h1);
        check("R9 wrapped", s_cnt, 32'h0);

        // R3 wrong key cannot clear flag
        tick_n(1);
        wr(4'h4, 32'h5A5A_5A00);
        tick_n(3); snap();
        check("R3 bad key keeps flag", s_csa, 32'h92);

        // R10 soft reset keeps the flag only
        soft_rst_n = 1'b0;
        tick_n(1);
        soft_rst_n = 1'b1;
        snap();
        check("R10 soft keeps flag", s_csa, 32'h10);
        check("R10 soft clears count", s_cnt, 32'h0);
        check("R10 soft clears ctrlB", s_csb, 32'h0);

        // R11 clear with bit4 zero
        tick_n(1);
        wr(4'h4, 32'hA5A5_A500);
        tick_n(2); snap();
        check("R11 flag cleared", s_csa, 32'h0);

        // R10 power-on reset clears the flag
        wr(4'h4, 32'hA5A5_A580);
        tick_n(2);
        wr(4'h0, 32'h5A5A_FFFF);
        tick_n(3); snap();
        check("R8 flag set again", s_csa, 32'h90);
        tick_n(1);
        por_n = 1'b0;
        tick_n(1);
        por_n = 1'b1;
        snap();
        check("R10 por clears flag", s_csa, 32'h0);
        check("R10 por clears request", {31'b0, s_req}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule